// File: doc/BRIEF.md
# Byte-Store Execute Unit

This unit carries out the four single-byte store operations of a 32-bit fixed-length instruction set. Two of them take a 16-bit displacement and two take an index register. In each pair, one form also writes the computed address back into its base register. An instruction word arrives with a valid strobe. The unit names the three registers it needs to an external 64-bit register file, which returns their values in the same cycle. From them it forms a 32-bit store address and places one byte on a memory write port, holding it there until memory acknowledges.

After the write has been taken, an update form writes the zero-extended address into the base register, and the unit gives a completion pulse so the fetch logic can advance the program counter by 4. In the cycle before the write is issued, and only while reservation tracking is enabled, the unit pulses an invalidate output that carries the store address. Invalid or unknown encodings raise a one-cycle illegal flag and leave memory and registers untouched. The unit accepts a new instruction only while idle.

Top module: `byte_store_unit`

## Requirements
- R1: Bit 0 is the most significant bit, so the port index is 31 minus that number. The opcode is in_instr[31:26], the source field [25:21], the base field [20:16], the index field [15:11], the displacement [15:0] and the extended opcode [10:1]. in_instr[0] is ignored. Opcode 38 is the displacement store and 39 the displacement store with update. Opcode 31 with extended opcode 215 is the indexed store, and with 247 the indexed store with update.
- R2: The store address is the low 32 bits of a wrapping 64-bit sum. The sum is the base value plus either the sign-extended displacement or the full index register value.
- R3: On the two forms without update, a base field of 0 selects the constant zero as base, not register 0.
- R4: mem_data is the low 8 bits of the source register. mem_we rises two cycles after acceptance, and mem_addr and mem_data hold steady while mem_we is high until the cycle in which mem_ack is sampled high.
- R5: In the cycle after the acknowledge, an update form asserts rf_we for one cycle. rf_waddr is the base field and rf_wdata is the store address zero-extended to 64 bits. The stored byte is the source value read before this update, even when source and base are the same register.
- R6: In the cycle after acceptance of a valid store, rsv_inv pulses for one cycle with rsv_addr equal to the store address, but only if rsv_en is high. mem_we asserts in the next cycle.
- R7: An update form with a base field of 0 raises illegal for one cycle, in the cycle after acceptance. No memory write, register write or done pulse follows.
- R8: A word that matches none of the four encodings raises illegal in the same way and has no other effect.
- R9: done pulses for one cycle in the cycle after the acknowledge. in_ready is high only while idle, which includes after reset and the cycle in which illegal is shown.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction word valid |
| in_instr | input | 32 | Instruction word |
| in_ready | output | 1 | Unit idle, word accepted when valid |
| rs_sel | output | 5 | Source register read index |
| ra_sel | output | 5 | Base register read index |
| rb_sel | output | 5 | Index register read index |
| rs_val | input | 64 | Source register value |
| ra_val | input | 64 | Base register value |
| rb_val | input | 64 | Index register value |
| rsv_en | input | 1 | Reservation tracking enabled |
| rsv_inv | output | 1 | Reservation invalidate pulse |
| rsv_addr | output | 32 | Address carried by the invalidate |
| mem_we | output | 1 | Byte write request |
| mem_addr | output | 32 | Byte write address |
| mem_data | output | 8 | Byte write data |
| mem_ack | input | 1 | Memory took the write |
| rf_we | output | 1 | Base register writeback enable |
| rf_waddr | output | 5 | Writeback register index |
| rf_wdata | output | 64 | Writeback value |
| illegal | output | 1 | Illegal-instruction pulse |
| done | output | 1 | Completion pulse, advance PC by 4 |

## Verification
The illegal pulse from a rejected word and the acceptance of the next word fall in the same cycle, because the unit returns to idle at once. The bench provokes this by presenting the next instruction on the very cycle it observes illegal, after invalid update forms and unknown encodings. It then judges that illegal is high with in_ready still high, and that the following store still gives its invalidate, byte, writeback and done with the expected values.

// File: rtl/bs_pkg.sv
package bs_pkg;
   localparam int RIDX_W = 5;
   localparam int INSN_W = 32;
   localparam int DISP_W = 16;
   localparam logic [5:0] OP_DISP  = 6'd38;
   localparam logic [5:0] OP_DISPU = 6'd39;
   localparam logic [5:0] OP_EXT   = 6'd31;
   localparam logic [9:0] XO_IDX   = 10'd215;
   localparam logic [9:0] XO_IDXU  = 10'd247;

   typedef enum logic [1:0] {S_IDLE, S_INV, S_WR, S_FIN} bs_state_t;

   typedef struct packed {
      logic              legal;
      logic              upd;
      logic              idx;
      logic [RIDX_W-1:0] rs;
      logic [RIDX_W-1:0] ra;
      logic [RIDX_W-1:0] rb;
      logic [DISP_W-1:0] disp;
   } bs_dec_t;
endpackage

// File: rtl/bs_decode.sv
module bs_decode
   import bs_pkg::*;
(
   input  logic [INSN_W-1:0] instr,
   output bs_dec_t           dec
);
   logic [5:0] opc;
   logic [9:0] xo;
   logic       known;
   logic       unused_rc;

   assign opc       = instr[31:26];
   assign xo        = instr[10:1];
   assign unused_rc = instr[0];

   always_comb begin
      dec.rs   = instr[25:21];
      dec.ra   = instr[20:16];
      dec.rb   = instr[15:11];
      dec.disp = instr[15:0];
      dec.upd  = 1'b0;
      dec.idx  = 1'b0;
      known    = 1'b0;
      if (opc == OP_DISP) begin
         known = 1'b1;
      end else if (opc == OP_DISPU) begin
         known   = 1'b1;
         dec.upd = 1'b1;
      end else if (opc == OP_EXT && xo == XO_IDX) begin
         known   = 1'b1;
         dec.idx = 1'b1;
      end else if (opc == OP_EXT && xo == XO_IDXU) begin
         known   = 1'b1;
         dec.idx = 1'b1;
         dec.upd = 1'b1;
      end
      dec.legal = known && !(dec.upd && (dec.ra == '0));
   end
endmodule

// File: rtl/bs_agen.sv
module bs_agen
   import bs_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int AW   = 32
) (
   input  bs_dec_t          dec,
   input  logic [XLEN-1:0]  ra_val,
   input  logic [XLEN-1:0]  rb_val,
   output logic [AW-1:0]    ea
);
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offs;
   logic [XLEN-1:0] sum;

   always_comb begin
      if (!dec.upd && (dec.ra == '0)) base = '0;
      else                            base = ra_val;
      if (dec.idx) offs = rb_val;
      else         offs = {{(XLEN-DISP_W){dec.disp[DISP_W-1]}}, dec.disp};
   end

   assign sum = base + offs;

   generate
      if (AW == XLEN) begin : g_full
         assign ea = sum;
      end else begin : g_trunc
         logic [XLEN-AW-1:0] unused_hi;
         assign unused_hi = sum[XLEN-1:AW];
         assign ea        = sum[AW-1:0];
      end
   endgenerate
endmodule

// File: rtl/bs_ctrl.sv
module bs_ctrl
   import bs_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int AW   = 32,
   parameter int BW   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  bs_dec_t           dec,
   input  logic [AW-1:0]     ea,
   input  logic [BW-1:0]     wbyte,
   input  logic              rsv_en,
   input  logic              mem_ack,
   output logic              idle,
   output logic              rsv_inv,
   output logic [AW-1:0]     rsv_addr,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [BW-1:0]     mem_data,
   output logic              rf_we,
   output logic [RIDX_W-1:0] rf_waddr,
   output logic [XLEN-1:0]   rf_wdata,
   output logic              illegal,
   output logic              done
);
   bs_state_t         st;
   logic [AW-1:0]     ea_q;
   logic [BW-1:0]     dat_q;
   logic              upd_q;
   logic [RIDX_W-1:0] base_q;
   logic              ill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         ea_q   <= '0;
         dat_q  <= '0;
         upd_q  <= 1'b0;
         base_q <= '0;
         ill_q  <= 1'b0;
      end else begin
         ill_q <= 1'b0;
         unique case (st)
            S_IDLE: if (go) begin
               if (dec.legal) begin
                  st     <= S_INV;
                  ea_q   <= ea;
                  dat_q  <= wbyte;
                  upd_q  <= dec.upd;
                  base_q <= dec.ra;
               end else begin
                  ill_q <= 1'b1;
               end
            end
            S_INV:   st <= S_WR;
            S_WR:    if (mem_ack) st <= S_FIN;
            S_FIN:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign idle     = (st == S_IDLE);
   assign rsv_inv  = (st == S_INV) && rsv_en;
   assign rsv_addr = ea_q;
   assign mem_we   = (st == S_WR);
   assign mem_addr = ea_q;
   assign mem_data = dat_q;
   assign rf_we    = (st == S_FIN) && upd_q;
   assign rf_waddr = base_q;
   assign rf_wdata = XLEN'(ea_q);
   assign illegal  = ill_q;
   assign done     = (st == S_FIN);
endmodule

// File: rtl/byte_store_unit.sv
module byte_store_unit
   import bs_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int AW   = 32,
   parameter int BW   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] in_instr,
   output logic              in_ready,
   output logic [RIDX_W-1:0] rs_sel,
   output logic [RIDX_W-1:0] ra_sel,
   output logic [RIDX_W-1:0] rb_sel,
   input  logic [XLEN-1:0]   rs_val,
   input  logic [XLEN-1:0]   ra_val,
   input  logic [XLEN-1:0]   rb_val,
   input  logic              rsv_en,
   output logic              rsv_inv,
   output logic [AW-1:0]     rsv_addr,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [BW-1:0]     mem_data,
   input  logic              mem_ack,
   output logic              rf_we,
   output logic [RIDX_W-1:0] rf_waddr,
   output logic [XLEN-1:0]   rf_wdata,
   output logic              illegal,
   output logic              done
);
   generate
      if (AW > XLEN || BW > XLEN || XLEN < DISP_W) begin : g_bad_cfg
         $error("byte_store_unit: widths out of range");
      end
   endgenerate

   bs_dec_t       dec;
   logic [AW-1:0] ea;
   logic          idle;
   logic [XLEN-BW-1:0] unused_rs_hi;

   assign unused_rs_hi = rs_val[XLEN-1:BW];

   bs_decode u_dec (
      .instr (in_instr),
      .dec   (dec)
   );

   assign rs_sel = dec.rs;
   assign ra_sel = dec.ra;
   assign rb_sel = dec.rb;

   bs_agen #(.XLEN(XLEN), .AW(AW)) u_agen (
      .dec    (dec),
      .ra_val (ra_val),
      .rb_val (rb_val),
      .ea     (ea)
   );

   bs_ctrl #(.XLEN(XLEN), .AW(AW), .BW(BW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (in_valid && idle),
      .dec      (dec),
      .ea       (ea),
      .wbyte    (rs_val[BW-1:0]),
      .rsv_en   (rsv_en),
      .mem_ack  (mem_ack),
      .idle     (idle),
      .rsv_inv  (rsv_inv),
      .rsv_addr (rsv_addr),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_data (mem_data),
      .rf_we    (rf_we),
      .rf_waddr (rf_waddr),
      .rf_wdata (rf_wdata),
      .illegal  (illegal),
      .done     (done)
   );

   assign in_ready = idle;
endmodule

// File: rtl/bs_chk.sv
module bs_chk #(
   parameter int XLEN = 64,
   parameter int AW   = 32,
   parameter int BW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_ready,
   input logic            rsv_inv,
   input logic [AW-1:0]   rsv_addr,
   input logic            mem_we,
   input logic [AW-1:0]   mem_addr,
   input logic [BW-1:0]   mem_data,
   input logic            mem_ack,
   input logic            rf_we,
   input logic [4:0]      rf_waddr,
   input logic [XLEN-1:0] rf_wdata,
   input logic            illegal,
   input logic            done
);
   // R4
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr) && $stable(mem_data)));

   // R6
   inv_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_inv |=> (mem_we && (mem_addr == $past(rsv_addr))));

   // R5
   wb_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $past(mem_we && mem_ack));

   // R5
   wb_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> ((rf_wdata >> AW) == '0));

   // R7
   wb_not_r0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (rf_waddr != 5'd0));

   // R9
   done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_we && mem_ack));

   // R7
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!mem_we && !rf_we && !done && !rsv_inv));

   // R9
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || done) |-> !in_ready);
endmodule

bind byte_store_unit bs_chk #(.XLEN(XLEN), .AW(AW), .BW(BW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_ready (in_ready),
   .rsv_inv  (rsv_inv),
   .rsv_addr (rsv_addr),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_data (mem_data),
   .mem_ack  (mem_ack),
   .rf_we    (rf_we),
   .rf_waddr (rf_waddr),
   .rf_wdata (rf_wdata),
   .illegal  (illegal),
   .done     (done)
);

// File: tb/sim_byte_store_unit.sv
`timescale 1ns/1ps
module sim_byte_store_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_instr = '0;
   logic        in_ready;
   logic [4:0]  rs_sel, ra_sel, rb_sel;
   logic [63:0] rs_val, ra_val, rb_val;
   logic        rsv_en = 1'b0;
   logic        rsv_inv;
   logic [31:0] rsv_addr;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [7:0]  mem_data;
   logic        mem_ack = 1'b0;
   logic        rf_we;
   logic [4:0]  rf_waddr;
   logic [63:0] rf_wdata;
   logic        illegal;
   logic        done;

   logic [63:0] regs [32];
   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   assign rs_val = regs[rs_sel];
   assign ra_val = regs[ra_sel];
   assign rb_val = regs[rb_sel];

   byte_store_unit u0 (.*);

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_d(input logic [5:0] op, input logic [4:0] s, input logic [4:0] a, input logic [15:0] d);
      return {op, s, a, d};
   endfunction

   function automatic logic [31:0] mk_x(input logic [4:0] s, input logic [4:0] a, input logic [4:0] b, input logic [9:0] xo, input logic rc);
      return {6'd31, s, a, b, xo, rc};
   endfunction

   // Expected behaviour computed from R1, R2, R3, R7, R8
   task automatic model(input logic [31:0] ins, output bit legal, output bit upd,
                        output logic [31:0] ea, output logic [7:0] dat, output logic [4:0] base);
      logic [5:0]  opc = ins[31:26];
      logic [9:0]  xo  = ins[10:1];
      logic [4:0]  rs  = ins[25:21];
      logic [4:0]  ra  = ins[20:16];
      logic [4:0]  rb  = ins[15:11];
      bit known = 0, idx = 0;
      logic [63:0] bv, ov, sum;
      upd = 0;
      if (opc == 6'd38) known = 1;
      else if (opc == 6'd39) begin known = 1; upd = 1; end
      else if (opc == 6'd31 && xo == 10'd215) begin known = 1; idx = 1; end
      else if (opc == 6'd31 && xo == 10'd247) begin known = 1; idx = 1; upd = 1; end
      bv  = (!upd && ra == 5'd0) ? 64'd0 : regs[ra];
      ov  = idx ? regs[rb] : {{48{ins[15]}}, ins[15:0]};
      sum = bv + ov;
      ea  = sum[31:0];
      dat = regs[rs][7:0];
      base = ra;
      legal = known && !(upd && ra == 5'd0);
   endtask

   // Called just after a negedge; returns just after a negedge.
   task automatic run(input logic [31:0] ins, input bit rsv);
      bit legal, upd;
      logic [31:0] ea;
      logic [7:0] dat;
      logic [4:0] base;
      int w;
      model(ins, legal, upd, ea, dat, base);
      chk(in_ready == 1'b1, "R9 ready before accept", 64'(in_ready), 64'd1);
      in_valid = 1'b1;
      in_instr = ins;
      rsv_en   = rsv;
      @(negedge clk);
      in_valid = 1'b0;
      in_instr = $urandom;
      if (!legal) begin
         chk(illegal == 1'b1, "R7/R8 illegal pulse", 64'(illegal), 64'd1);
         chk(!mem_we && !rsv_inv && !done && !rf_we, "R8 no side effects",
             {60'd0, mem_we, rsv_inv, done, rf_we}, 64'd0);
         chk(in_ready == 1'b1, "R9 ready with illegal", 64'(in_ready), 64'd1);
         return;
      end
      chk(illegal == 1'b0, "R1 legal word not flagged", 64'(illegal), 64'd0);
      chk(rsv_inv == rsv, "R6 invalidate gated by enable", 64'(rsv_inv), 64'(rsv));
      if (rsv) chk(rsv_addr == ea, "R6 invalidate address", 64'(rsv_addr), 64'(ea));
      chk(mem_we == 1'b0, "R6 write after invalidate", 64'(mem_we), 64'd0);
      chk(in_ready == 1'b0, "R9 busy not ready", 64'(in_ready), 64'd0);
      @(negedge clk);
      rsv_en = $urandom_range(0, 1);
      chk(rsv_inv == 1'b0, "R6 single pulse", 64'(rsv_inv), 64'd0);
      chk(mem_we == 1'b1, "R4 write request", 64'(mem_we), 64'd1);
      chk(mem_addr == ea, "R2 store address", 64'(mem_addr), 64'(ea));
      chk(mem_data == dat, "R4 store byte", 64'(mem_data), 64'(dat));
      w = $urandom_range(0, 3);
      for (int i = 0; i < w; i++) begin
         @(negedge clk);
         chk(mem_we && mem_addr == ea && mem_data == dat, "R4 hold until ack",
             {23'd0, mem_we, mem_addr, mem_data}, {23'd1, ea, dat});
         chk(!done && !rf_we, "R9 no done before ack", {62'd0, done, rf_we}, 64'd0);
      end
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      chk(done == 1'b1, "R9 done after ack", 64'(done), 64'd1);
      chk(mem_we == 1'b0, "R4 write dropped after ack", 64'(mem_we), 64'd0);
      chk(rf_we == upd, "R5 writeback enable", 64'(rf_we), 64'(upd));
      if (upd) begin
         chk(rf_waddr == base, "R5 writeback index", 64'(rf_waddr), 64'(base));
         chk(rf_wdata == {32'd0, ea}, "R5 writeback value", rf_wdata, {32'd0, ea});
         regs[base] = {32'd0, ea};
      end
      @(negedge clk);
      chk(!done && !rf_we && in_ready, "R9 back to idle",
          {61'd0, done, rf_we, in_ready}, 64'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL R9 watchdog expired actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed1234));
      for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(in_ready && !mem_we && !rf_we && !done && !illegal && !rsv_inv, "R9 reset state",
          {58'd0, in_ready, mem_we, rf_we, done, illegal, rsv_inv}, 64'h20);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 literal zero base with negative displacement (R2 sign extension)
      run(mk_d(6'd38, 5'd2, 5'd0, 16'hFFFC), 1'b1);
      // R3 indexed form with zero base
      run(mk_x(5'd3, 5'd0, 5'd5, 10'd215, 1'b0), 1'b1);
      // R7 update forms with base 0, each followed at once by a valid store
      run(mk_d(6'd39, 5'd4, 5'd0, 16'h0010), 1'b1);
      run(mk_d(6'd39, 5'd4, 5'd6, 16'h0010), 1'b1);
      run(mk_x(5'd4, 5'd0, 5'd6, 10'd247, 1'b1), 1'b0);
      run(mk_x(5'd8, 5'd9, 5'd10, 10'd247, 1'b0), 1'b1);
      // R1 bit 0 ignored on indexed form
      run(mk_x(5'd1, 5'd2, 5'd3, 10'd215, 1'b1), 1'b0);
      // R8 unknown extended opcode and unknown primary opcode
      run(mk_x(5'd1, 5'd2, 5'd3, 10'd151, 1'b0), 1'b1);
      run(mk_d(6'd12, 5'd1, 5'd2, 16'h1234), 1'b1);
      run(mk_d(6'd38, 5'd1, 5'd2, 16'h0004), 1'b1);
      // R5 source equals base on update form
      regs[7] = 64'h0123_4567_89AB_CDEF;
      run(mk_d(6'd39, 5'd7, 5'd7, 16'h0001), 1'b1);
      chk(regs[7] == 64'h0000_0000_89AB_CDF0, "R5 base updated", regs[7], 64'h89AB_CDF0);
      // R2 64-bit wrap
      regs[3] = 64'hFFFF_FFFF_FFFF_FFF0;
      regs[4] = 64'h0000_0000_0000_0020;
      run(mk_x(5'd5, 5'd3, 5'd4, 10'd247, 1'b0), 1'b0);
      chk(regs[3] == 64'h10, "R2 wrapped address written back", regs[3], 64'h10);

      for (int n = 0; n < 400; n++) begin
         logic [4:0] s = 5'($urandom), a = 5'($urandom), b = 5'($urandom);
         logic [31:0] ins;
         int k = $urandom_range(0, 5);
         if ($urandom_range(0, 7) == 0) a = 5'd0;
         if ($urandom_range(0, 15) == 0) regs[$urandom_range(0, 31)] = {$urandom, $urandom};
         case (k)
            0: ins = mk_d(6'd38, s, a, 16'($urandom));
            1: ins = mk_d(6'd39, s, a, 16'($urandom));
            2: ins = mk_x(s, a, b, 10'd215, 1'($urandom));
            3: ins = mk_x(s, a, b, 10'd247, 1'($urandom));
            4: ins = mk_x(s, a, b, 10'($urandom), 1'($urandom));
            default: ins = $urandom;
         endcase
         run(ins, 1'($urandom));
      end

      @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule